// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between on-chip logic and an external asynchronous static RAM of 16K words by 4 bits. On-chip logic hands it one word at a time through a valid/ready request port: a direction bit, a 14-bit word address and, for stores, a 4-bit data value. The block turns each request into the chip-select, write-strobe, address and data pin activity the RAM needs. For loads it returns the fetched word together with a one-cycle valid pulse.

Every pin is driven from a register, so the pins change only on clock edges. The timing limits of the RAM are given as picosecond parameters together with the clock period. The block converts them into whole clock counts by rounding up, and never uses fewer than one cycle. Between transfers the RAM is left deselected and the block's data driver is switched off. Bus ownership is handled explicitly. The write data stays on the bus for one cycle after the strobes rise. A store that directly follows a load is held back by one cycle, which gives the RAM time to release the shared lines.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle with no transfer in progress, `ram_ce_n` and `ram_we_n` are 1, `ram_dq_oe` is 0 and `req_ready` is 1.
- R2: An accepted load drives `ram_ce_n` low with `ram_we_n` high for exactly RD_CYC cycles. The word on `ram_dq_in` is captured at the edge that ends the last of those cycles, and in the following cycle `rd_valid` is 1 with that word on `rd_data`. `rd_valid` is 0 in all other cycles.
- R3: For a store, `ram_ce_n` and `ram_we_n` fall on the same clock edge, stay low together for exactly WR_CYC cycles and rise on the same edge. `ram_we_n` is never low while `ram_ce_n` is high.
- R4: `ram_dq_oe` is 1 with the store data on `ram_dq_out` in every cycle the write strobe is low, and also in the cycle right after it rises.
- R5: `ram_addr` holds the request's address and does not change while `ram_ce_n` and `ram_we_n` are both low.
- R6: A store accepted in the last cycle of a load is preceded by exactly one cycle with `ram_ce_n` high and `ram_dq_oe` low. A load-active cycle (chip select low, strobe high) is never directly followed by a write-active cycle.
- R7: `ram_dq_oe` is never 1 while `ram_ce_n` is 0 and `ram_we_n` is 1.
- R8: `req_ready` is 1 in idle, in the data-hold cycle after a store, and in the last cycle of a load. It is 0 in all other busy cycles. A request is taken on an edge where `req_valid` and `req_ready` are both 1.
- R9: A load or store accepted in the last load cycle or in the store hold cycle starts on the next edge with no idle cycle. Consecutive loads keep `ram_ce_n` low while the address moves to the next word.
- R10: RD_CYC is max(1, ceil(max(T_RC_PS, T_AA_PS)/CLK_PS)). WR_CYC is the largest of 1, ceil(T_WP_PS/CLK_PS), ceil(T_DW_PS/CLK_PS) and ceil(T_WC_PS/CLK_PS)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block takes the request on this edge |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| rd_valid | output | 1 | One-cycle pulse marking load data |
| rd_data | output | DW | Loaded word |
| ram_addr | output | AW | RAM address pins |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | DW | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Enable for the data driver |
| ram_dq_in | input | DW | Data returned by the RAM |

## Verification
The bench targets the hand-offs between transfers. These are a load followed at once by a store, a load followed by a load, a store followed by a load from its hold cycle, and a store followed by a store. If a design skips the turnaround, the write-active cycle comes straight after a load, and its driver fights the RAM's outputs. If it drops the data one cycle early, the hold cycle shows the driver off. If it samples read data one edge late or early, the word returned is wrong or belongs to the previous address. The bench also uses stretched timing parameters, so a wrong rounding or an off-by-one in the counter shows up as a strobe of the wrong length. It exercises addresses 0 and 3FFF hex.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_WSTRB,
    S_WHOLD,
    S_TURN
  } seq_t;

  // whole clock cycles covering a time, never fewer than one
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_rcap.sv
module asram_rcap #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          vld
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout <= '0;
    else if (cap) dout <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= cap;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW      = 14,
  parameter int DW      = 4,
  parameter int CLK_PS  = 20000,
  parameter int T_RC_PS = 25000,
  parameter int T_AA_PS = 25000,
  parameter int T_WP_PS = 20000,
  parameter int T_DW_PS = 13000,
  parameter int T_WC_PS = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int RD_CYC = max2(cycles_for(T_RC_PS, CLK_PS), cycles_for(T_AA_PS, CLK_PS));
  localparam int WR_CYC = max2(max2(cycles_for(T_WP_PS, CLK_PS), cycles_for(T_DW_PS, CLK_PS)),
                               max2(cycles_for(T_WC_PS, CLK_PS) - 1, 1));
  localparam int CW     = $clog2(max2(RD_CYC, WR_CYC) + 1);
  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

  seq_t          st_q, st_d;
  logic          ce_n_q, ce_n_d;
  logic          we_n_q, we_n_d;
  logic          oe_q, oe_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic          cap;
  logic          accept;

  assign req_ready = (st_q == S_IDLE) | (st_q == S_WHOLD) | ((st_q == S_READ) & cnt_zero);
  assign accept    = req_valid & req_ready;

  // next-state and next-pin logic
  always_comb begin
    st_d     = st_q;
    ce_n_d   = ce_n_q;
    we_n_d   = we_n_q;
    oe_d     = oe_q;
    addr_d   = addr_q;
    wd_d     = wd_q;
    cnt_load = 1'b0;
    cnt_val  = RD_LOAD;
    cap      = 1'b0;
    if (accept) begin
      addr_d = req_addr;
      wd_d   = req_wdata;
    end
    case (st_q)
      S_IDLE, S_WHOLD: begin
        if (accept && req_we) begin
          st_d     = S_WSTRB;
          ce_n_d   = 1'b0;
          we_n_d   = 1'b0;
          oe_d     = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = WR_LOAD;
        end else if (accept) begin
          st_d     = S_READ;
          ce_n_d   = 1'b0;
          we_n_d   = 1'b1;
          oe_d     = 1'b0;
          cnt_load = 1'b1;
        end else begin
          st_d   = S_IDLE;
          ce_n_d = 1'b1;
          oe_d   = 1'b0;
        end
      end
      S_READ: begin
        if (cnt_zero) begin
          cap = 1'b1;
          if (accept && req_we) begin
            st_d   = S_TURN;
            ce_n_d = 1'b1;
          end else if (accept) begin
            cnt_load = 1'b1;
          end else begin
            st_d   = S_IDLE;
            ce_n_d = 1'b1;
          end
        end
      end
      S_WSTRB: begin
        if (cnt_zero) begin
          st_d   = S_WHOLD;
          ce_n_d = 1'b1;
          we_n_d = 1'b1;
        end
      end
      S_TURN: begin
        st_d     = S_WSTRB;
        ce_n_d   = 1'b0;
        we_n_d   = 1'b0;
        oe_d     = 1'b1;
        cnt_load = 1'b1;
        cnt_val  = WR_LOAD;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_d;
      ce_n_q <= ce_n_d;
      we_n_q <= we_n_d;
      oe_q   <= oe_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  asram_cnt #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_rcap #(.DW(DW)) u_rcap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .din   (ram_dq_in),
    .dout  (rd_data),
    .vld   (rd_valid)
  );

  assign ram_addr   = addr_q;
  assign ram_ce_n   = ce_n_q;
  assign ram_we_n   = we_n_q;
  assign ram_dq_oe  = oe_q;
  assign ram_dq_out = wd_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_ce_n,
  input logic          ram_we_n,
  input logic          ram_dq_oe,
  input logic [AW-1:0] ram_addr
);

  p_strobe_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> $fell(ram_ce_n));

  p_strobe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> $rose(ram_ce_n));

  p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_ce_n);

  p_data_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_dq_oe);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> ram_dq_oe);

  p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && !ram_we_n && $past(!ram_ce_n) && $past(!ram_we_n)) |-> $stable(ram_addr));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dq_oe && !ram_ce_n && ram_we_n));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ram_ce_n) && $past(ram_we_n)) |-> !(!ram_ce_n && !ram_we_n));

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ram_ce_n  (ram_ce_n),
  .ram_we_n  (ram_we_n),
  .ram_dq_oe (ram_dq_oe),
  .ram_addr  (ram_addr)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

  localparam int RDC = 3;   // ceil(55000/20000)
  localparam int WRC = 3;   // ceil(45000/20000)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [13:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid, ram_ce_n, ram_we_n, ram_dq_oe;
  logic [3:0]  rd_data, ram_dq_out;
  logic [3:0]  ram_dq_in = '0;
  logic [13:0] ram_addr;

  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  asram_ctrl #(.CLK_PS(20000), .T_RC_PS(55000), .T_WP_PS(45000)) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // RAM pin model
  logic [3:0] sram [int];
  always @(posedge clk)
    if (!ram_ce_n && !ram_we_n && ram_dq_oe) sram[int'(ram_addr)] = ram_dq_out;
  always @(negedge clk)
    if (!ram_ce_n && ram_we_n)
      ram_dq_in <= sram.exists(int'(ram_addr)) ? sram[int'(ram_addr)] : 4'h0;
    else
      ram_dq_in <= 4'h0;

  // reference model: 0 idle, 1 load, 2 strobe, 3 hold, 4 turnaround
  logic [3:0] ref_mem [int];
  int         m_mode, m_cnt;
  logic       m_ce_n, m_we_n, m_oe, m_rv;
  logic [13:0] m_addr;
  logic [3:0]  m_dq, m_rd;
  logic        m_ready;
  assign m_ready = (m_mode == 0) || (m_mode == 3) || (m_mode == 1 && m_cnt == 0);

  function automatic logic [3:0] ref_get(input logic [13:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
  endfunction

  task automatic m_start();
    m_addr = req_addr;
    m_dq   = req_wdata;
    m_ce_n = 1'b0;
    if (req_we) begin
      m_mode = 2; m_we_n = 1'b0; m_oe = 1'b1; m_cnt = WRC - 1;
      ref_mem[int'(req_addr)] = req_wdata;
    end else begin
      m_mode = 1; m_we_n = 1'b1; m_oe = 1'b0; m_cnt = RDC - 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_ce_n = 1'b1; m_we_n = 1'b1; m_oe = 1'b0;
      m_rv = 1'b0; m_addr = '0; m_dq = '0; m_rd = '0;
    end else begin
      logic acc;
      acc  = req_valid && m_ready;
      m_rv = 1'b0;
      case (m_mode)
        0, 3: if (acc) m_start(); else begin m_mode = 0; m_ce_n = 1'b1; m_oe = 1'b0; end
        1: if (m_cnt > 0) m_cnt--;
           else begin
             m_rv = 1'b1; m_rd = ref_get(m_addr);
             if (acc && req_we) begin
               m_mode = 4; m_ce_n = 1'b1; m_addr = req_addr; m_dq = req_wdata;
             end else if (acc) m_start();
             else begin m_mode = 0; m_ce_n = 1'b1; end
           end
        2: if (m_cnt > 0) m_cnt--;
           else begin m_mode = 3; m_ce_n = 1'b1; m_we_n = 1'b1; end
        default: begin
          m_mode = 2; m_ce_n = 1'b0; m_we_n = 1'b0; m_oe = 1'b1; m_cnt = WRC - 1;
          ref_mem[int'(m_addr)] = m_dq;
        end
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison and protocol monitors
  logic        prev_rd, prev_we_low;
  logic [13:0] prev_addr;
  int          bad6 = 0, seen9 = 0, wrun = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ce_n", ram_ce_n, m_ce_n);
      chk("R3 we_n", ram_we_n, m_we_n);
      chk("R4 dq_oe", ram_dq_oe, m_oe);
      chk("R8 ready", req_ready, m_ready);
      chk("R2 rd_valid", rd_valid, m_rv);
      if (m_oe)    chk("R4 dq_out", ram_dq_out, m_dq);
      if (!m_ce_n) chk("R5 addr", ram_addr, m_addr);
      if (m_rv)    chk("R2 rd_data", rd_data, m_rd);
      if (ram_dq_oe && !ram_ce_n && ram_we_n) chk("R7 contention", 1, 0);
      if (prev_rd && !ram_ce_n && !ram_we_n) bad6++;
      if (prev_rd && !ram_ce_n && ram_we_n && ram_addr != prev_addr) seen9++;
      if (!ram_we_n) wrun++;
      else if (prev_we_low) begin chk("R10 strobe length", wrun, WRC); wrun = 0; end
      prev_rd     = !ram_ce_n && ram_we_n;
      prev_we_low = !ram_we_n;
      prev_addr   = ram_addr;
    end else begin
      prev_rd = 1'b0; prev_we_low = 1'b0; prev_addr = '0;
    end
  end

  task automatic issue(input logic we, input logic [13:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 ce_n", ram_ce_n, 1);
    chk("R1 we_n", ram_we_n, 1);
    chk("R1 dq_oe", ram_dq_oe, 0);
    // store then load from the hold cycle (R9)
    issue(1'b1, 14'h0005, 4'hA);
    issue(1'b0, 14'h0005, 4'h0);
    idle(3);
    // back-to-back stores with boundary addresses
    issue(1'b1, 14'h0000, 4'h3);
    issue(1'b1, 14'h3FFF, 4'hC);
    issue(1'b1, 14'h1234, 4'h7);
    // back-to-back loads (R9)
    issue(1'b0, 14'h0000, 4'h0);
    issue(1'b0, 14'h3FFF, 4'h0);
    issue(1'b0, 14'h1234, 4'h0);
    // load followed at once by a store: turnaround (R6)
    issue(1'b1, 14'h0100, 4'hE);
    issue(1'b0, 14'h0100, 4'h0);
    idle(4);
    chk("R1 idle ce_n", ram_ce_n, 1);
    chk("R1 idle dq_oe", ram_dq_oe, 0);
    for (int i = 0; i < 60; i++) begin
      issue(1'($urandom_range(0, 1)), 14'($urandom_range(0, 7) * 14'h0801),
            4'($urandom_range(0, 15)));
      if (i % 9 == 0) idle(i % 4);
    end
    idle(10);
    chk("R6 no direct load-to-store", bad6, 0);
    chk("R9 load-to-load address step", int'(seen9 > 0), 1);
    report();
  end

endmodule